// File: doc/BRIEF.md
# Periodic Interrupt Pulse Generator

This block produces an active-low, open-drain style output and the status flag that mirrors it, for a real-time clock. A four-bit control word chooses one of four time events (a 64 Hz tick, or the carry out of the seconds, minutes or hours counters). It also chooses whether the output behaves as a latched interrupt or as a fixed-width pulse, and whether the output is masked. When the chosen event arrives while the output is released, the output goes low and the flag reads 1.

In latched mode the output stays low until software issues a clear strobe. In pulse mode the output releases itself after a fixed number of time-base ticks, 256 ticks of the 32.768 kHz base by default, which gives 7.8125 ms. While the clock's stop control is active, a pulse in progress is frozen at its current level and count. The time-base tick, the event pulses and the clear strobe are single-cycle enables in the system clock domain.

Top module: `periodic_pulse_gen`

## Requirements
- R1: After reset the output is released (`pin_out_n` = 1) and `irq_flag` = 0.
- R2: Control bits [3:2] select the event source: 00 = `tick_64hz`, 01 = `carry_sec`, 10 = `carry_min`, 11 = `carry_hour`. Pulses on the unselected sources have no effect on the output.
- R3: While control bit 0 (mask) is 1, the output is released one cycle later and no event asserts it.
- R4: With control bit 1 = 1 (latched mode), a selected event drives the output low in the next cycle, and it stays low with no time limit until a clear strobe.
- R5: While the output is low, further events are ignored: they neither extend nor restart anything.
- R6: With control bit 1 = 0 (pulse mode), the output is released in the cycle after the WIDTH_TICKS-th `base_tick` counted after the cycle of the event. A `base_tick` in the event cycle itself is not counted.
- R7: In pulse mode, while `stop` is 1, the output holds its level, the width count does not advance, and events do not start a pulse.
- R8: A clear strobe releases the output in the next cycle. When a clear and an event arrive in the same cycle, the clear wins and the event is lost.
- R9: `irq_flag` is always the inverse of `pin_out_n`.
- R10: In pulse mode on the 64 Hz source, with one `base_tick` per cycle and a 64 Hz tick every 2*WIDTH_TICKS cycles, the output is low for exactly half of each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | One-cycle enable at the 32.768 kHz time-base rate |
| tick_64hz | input | 1 | One-cycle 64 Hz event |
| carry_sec | input | 1 | One-cycle seconds carry |
| carry_min | input | 1 | One-cycle minutes carry |
| carry_hour | input | 1 | One-cycle hours carry |
| ctrl_e | input | 4 | [3:2] source select, [1] latched(1)/pulse(0), [0] mask |
| stop | input | 1 | Clock stop control; freezes a pulse-mode output |
| irq_clr | input | 1 | One-cycle strobe: software wrote 0 to the flag |
| pin_out_n | output | 1 | Output level, 0 = driven low, 1 = released |
| irq_flag | output | 1 | Status flag, 1 while the output is low |

## Verification
The hardest case to reach is a pulse-mode output frozen by `stop` partway through its width, followed by its release on exactly the right tick. Reaching it needs a started pulse, a known number of counted base ticks, and then a stop window that is longer than the remaining width. Directed sequences drive the base tick every cycle, so the tick count equals the cycle count, and they place the stop window in the middle of the pulse. A random phase with rare events and a half-rate base tick then mixes mode switches, masks and clears against a bench model that is computed each cycle.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    typedef enum logic {
        MODE_PULSE = 1'b0,
        MODE_LATCH = 1'b1
    } out_mode_e;

    typedef enum logic [1:0] {
        SRC_TICK64 = 2'd0,
        SRC_SEC    = 2'd1,
        SRC_MIN    = 2'd2,
        SRC_HOUR   = 2'd3
    } src_sel_e;

    // bit layout of the control word: [3:2] source, [1] mode, [0] mask
    typedef struct packed {
        src_sel_e  source;
        out_mode_e mode;
        logic      mask;
    } ctrl_word_t;

    localparam int NUM_SOURCES = 4;

    function automatic ctrl_word_t decode_ctrl(input logic [3:0] raw);
        return ctrl_word_t'(raw);
    endfunction

    function automatic logic is_pulse_mode(input ctrl_word_t c);
        return c.mode == MODE_PULSE;
    endfunction

endpackage

// File: rtl/ppg_src_sel.sv
module ppg_src_sel #(
    parameter int NSRC = 4,
    localparam int SELW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_pulse,
    input  logic [SELW-1:0] sel,
    output logic            evt
);
    logic [NSRC-1:0] hit;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            assign hit[i] = src_pulse[i] && (sel == SELW'(i));
        end
    endgenerate

    assign evt = |hit;

    // only the chosen source may produce an event
    assert_only_selected_R2: assert property (@(posedge clk) disable iff (rst)
        evt |-> src_pulse[sel]);

endmodule

// File: rtl/ppg_width_timer.sv
module ppg_width_timer #(
    parameter int WIDTH = 256,
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run_en,
    input  logic tick,
    output logic expire
);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (run_en && tick && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run_en && tick && (cnt == LAST);

    // count is frozen whenever it is neither restarted nor enabled
    assert_frozen_count_R7: assert property (@(posedge clk) disable iff (rst)
        (!start && !run_en) |=> $stable(cnt));

endmodule

// File: rtl/ppg_out_ctrl.sv
module ppg_out_ctrl
    import ppg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctrl_word_t cfg,
    input  logic       evt,
    input  logic       stop,
    input  logic       clr,
    input  logic       expire,
    output logic       low_q,
    output logic       start,
    output logic       run_en
);
    logic pulse_mode;
    logic frozen;
    logic release_now;
    logic low_d;

    always_comb begin
        pulse_mode  = is_pulse_mode(cfg);
        frozen      = pulse_mode && stop;
        start       = !cfg.mask && !clr && !low_q && evt && !frozen;
        run_en      = low_q && pulse_mode && !stop;
        release_now = cfg.mask || clr || expire;
        if (release_now)  low_d = 1'b0;
        else if (start)   low_d = 1'b1;
        else              low_d = low_q;
    end

    always_ff @(posedge clk) begin
        if (rst) low_q <= 1'b0;
        else     low_q <= low_d;
    end

    assert_mask_release_R3: assert property (@(posedge clk) disable iff (rst)
        cfg.mask |=> !low_q);

    assert_latched_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (low_q && cfg.mode == MODE_LATCH && !clr && !cfg.mask) |=> low_q);

    assert_events_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (low_q && !clr && !cfg.mask && !expire) |=> low_q);

    assert_release_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(low_q) |-> $past(cfg.mask || clr || expire));

    assert_stop_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (pulse_mode && stop && !clr && !cfg.mask) |=> $stable(low_q));

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> !low_q);

endmodule

// File: rtl/periodic_pulse_gen.sv
module periodic_pulse_gen
    import ppg_pkg::*;
#(
    parameter int WIDTH_TICKS = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       base_tick,
    input  logic       tick_64hz,
    input  logic       carry_sec,
    input  logic       carry_min,
    input  logic       carry_hour,
    input  logic [3:0] ctrl_e,
    input  logic       stop,
    input  logic       irq_clr,
    output logic       pin_out_n,
    output logic       irq_flag
);
    ctrl_word_t             cfg;
    logic [NUM_SOURCES-1:0] sources;
    logic                   evt;
    logic                   low_q;
    logic                   start;
    logic                   run_en;
    logic                   expire;

    assign cfg     = decode_ctrl(ctrl_e);
    assign sources = {carry_hour, carry_min, carry_sec, tick_64hz};

    ppg_src_sel #(.NSRC(NUM_SOURCES)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .src_pulse (sources),
        .sel       (cfg.source),
        .evt       (evt)
    );

    ppg_out_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .cfg    (cfg),
        .evt    (evt),
        .stop   (stop),
        .clr    (irq_clr),
        .expire (expire),
        .low_q  (low_q),
        .start  (start),
        .run_en (run_en)
    );

    ppg_width_timer #(.WIDTH(WIDTH_TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .run_en (run_en),
        .tick   (base_tick),
        .expire (expire)
    );

    assign pin_out_n = !low_q;
    assign irq_flag  = low_q;

endmodule

// File: tb/periodic_pulse_gen_tb.sv
module periodic_pulse_gen_tb;
    localparam int W = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic base_tick = 0, tick_64hz = 0, carry_sec = 0, carry_min = 0, carry_hour = 0;
    logic [3:0] ctrl_e = 4'b0000;
    logic stop = 0, irq_clr = 0;
    logic pin_out_n, irq_flag;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit m_low = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    periodic_pulse_gen #(.WIDTH_TICKS(W)) u_dut (
        .clk(clk), .rst(rst), .base_tick(base_tick), .tick_64hz(tick_64hz),
        .carry_sec(carry_sec), .carry_min(carry_min), .carry_hour(carry_hour),
        .ctrl_e(ctrl_e), .stop(stop), .irq_clr(irq_clr),
        .pin_out_n(pin_out_n), .irq_flag(irq_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit sel_event(input logic [3:0] c, input logic t64, s, m, h);
        case (c[3:2])
            2'b00: return t64;
            2'b01: return s;
            2'b10: return m;
            default: return h;
        endcase
    endfunction

    // one clock cycle: drive, update the model from the requirements, compare
    task automatic cyc(input logic t64, s, m, h, input logic [3:0] c,
                       input logic st, cl, b);
        bit ev, pulse;
        @(negedge clk);
        tick_64hz = t64; carry_sec = s; carry_min = m; carry_hour = h;
        ctrl_e = c; stop = st; irq_clr = cl; base_tick = b;
        ev = sel_event(c, t64, s, m, h);
        pulse = !c[1];
        @(posedge clk);
        if (c[0] || cl) begin
            m_low = 0;
        end else if (m_low) begin
            if (pulse && !st && b) begin
                if (m_cnt == W - 1) m_low = 0;
                else m_cnt++;
            end
        end else if (ev && !(pulse && st)) begin
            m_low = 1;
            m_cnt = 0;
        end
        #1;
        chk(pin_out_n == !m_low, "model R2 R4 R5 R6 R7 R8 pin", pin_out_n, !m_low);
        chk(irq_flag == !pin_out_n, "R9 flag inverse", irq_flag, !pin_out_n);
    endtask

    task automatic idle(input logic [3:0] c, input int n, input logic st, input logic b);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, c, st, 0, b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lowcnt;
        void'($urandom(32'h1badcafe));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk(pin_out_n == 1, "R1 reset pin", pin_out_n, 1);
        chk(irq_flag == 0, "R1 reset flag", irq_flag, 0);

        // latched mode on the seconds carry: ctrl = 01_1_0
        cyc(0, 0, 1, 0, 4'b0110, 0, 0, 1);
        chk(pin_out_n == 1, "R2 unselected minute carry", pin_out_n, 1);
        cyc(1, 0, 0, 1, 4'b0110, 0, 0, 1);
        chk(pin_out_n == 1, "R2 unselected tick and hour", pin_out_n, 1);
        cyc(0, 1, 0, 0, 4'b0110, 0, 0, 1);
        chk(pin_out_n == 0, "R4 latched assert", pin_out_n, 0);
        idle(4'b0110, 600, 0, 1);
        chk(pin_out_n == 0, "R4 latched no timeout", pin_out_n, 0);
        cyc(0, 1, 0, 0, 4'b0110, 0, 0, 1);
        chk(irq_flag == 1, "R5 event while set", irq_flag, 1);
        cyc(0, 1, 0, 0, 4'b0110, 0, 1, 1);
        chk(pin_out_n == 1, "R8 clear with event", pin_out_n, 1);
        cyc(0, 1, 0, 0, 4'b0110, 0, 1, 0);
        chk(pin_out_n == 1, "R8 clear beats event from released", pin_out_n, 1);

        // mask
        cyc(0, 1, 0, 0, 4'b0111, 0, 0, 1);
        chk(pin_out_n == 1, "R3 masked event", pin_out_n, 1);
        cyc(0, 1, 0, 0, 4'b0110, 0, 0, 1);
        cyc(0, 0, 0, 0, 4'b0111, 0, 0, 1);
        chk(pin_out_n == 1, "R3 mask releases", pin_out_n, 1);

        // pulse mode width on the seconds carry: ctrl = 01_0_0
        cyc(0, 1, 0, 0, 4'b0100, 0, 0, 1);
        chk(pin_out_n == 0, "R6 pulse start", pin_out_n, 0);
        idle(4'b0100, W - 1, 0, 1);
        chk(pin_out_n == 0, "R6 still low before last tick", pin_out_n, 0);
        idle(4'b0100, 1, 0, 1);
        chk(pin_out_n == 1, "R6 released after last tick", pin_out_n, 1);

        // stop freezes a pulse midway
        cyc(0, 1, 0, 0, 4'b0100, 0, 0, 1);
        idle(4'b0100, 100, 0, 1);
        idle(4'b0100, 500, 1, 1);
        chk(pin_out_n == 0, "R7 frozen low under stop", pin_out_n, 0);
        idle(4'b0100, W - 101, 0, 1);
        chk(pin_out_n == 0, "R7 count held during stop", pin_out_n, 0);
        idle(4'b0100, 1, 0, 1);
        chk(pin_out_n == 1, "R7 release after resume", pin_out_n, 1);
        cyc(0, 1, 0, 0, 4'b0100, 1, 0, 1);
        chk(pin_out_n == 1, "R7 no start under stop", pin_out_n, 1);

        // half duty on the 64 Hz source in pulse mode
        lowcnt = 0;
        for (int i = 0; i < 4 * 2 * W; i++) begin
            cyc((i % (2 * W)) == 0, 0, 0, 0, 4'b0000, 0, 0, 1);
            if (!pin_out_n) lowcnt++;
        end
        chk(lowcnt == 4 * W, "R10 half duty", lowcnt, 4 * W);

        // random phase
        for (int i = 0; i < 20000; i++) begin
            logic [3:0] c;
            if (i % 700 == 0) c = 4'($urandom_range(0, 15));
            else c = ctrl_e;
            if (($urandom % 8) == 0) c[0] = 0;
            cyc(($urandom % 200) == 0, ($urandom % 200) == 0,
                ($urandom % 200) == 0, ($urandom % 200) == 0, c,
                ($urandom % 50) == 0, ($urandom % 900) == 0, $urandom % 2);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule